// File: doc/BRIEF.md
# Variable-Block Carry-Select Adder

This block adds two WIDTH-bit operands and a carry input. It returns a WIDTH-bit sum and a carry output, and it has no clock and no storage. The operand width is cut into a chain of ripple-carry segments.

The least significant segment holds a single ripple adder, driven straight from the carry input. Each segment above it holds two ripple adders that work at the same time. One assumes the carry arriving from below is 0, and the other assumes it is 1. A multiplexer per segment takes the carry that the segment below has resolved. It uses that carry to pick the sum slice and the outgoing carry. The outgoing carry then drives the next segment's multiplexer, and the carry leaving the top segment is the adder's carry output.

Segment sizes come from one of two schedules. In the list schedule, the sizes are given explicitly, least significant segment first. Sizes that grow toward the top let a segment's ripple delay finish in about the time the select chain takes to reach it. In the uniform schedule, every segment has the same size, and the top segment takes whatever bits remain. Elaboration stops with an error if the sizes do not add up to WIDTH or if any size is zero.

Top module: `csel_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals the arithmetic value `a + b + cin`, computed WIDTH+1 bits wide. The default configuration is 16 bits with segment sizes 2, 2, 3, 4, 5, least significant first.
- R2: A carry produced below any bit position reaches that position and every position above it. An operand with its low k bits all ones, plus a carry input of 1, yields exactly bit k set. When k equals WIDTH, the result is a zero sum with `cout` = 1.
- R3: The least significant segment depends only on its operand bits and the true carry input, with no speculation. The carry input alone moves the sum by one, and an all-ones operand with `cin` = 0 passes through with `cout` = 0.
- R4: Each higher segment's sum slice and outgoing carry equal the result of its ripple adder that assumed the carry which actually arrived. The 1-assumption carry is set whenever the 0-assumption carry is set.
- R5: In the list schedule at 64 bits, with segment sizes 2, 3, 4, 5, 6, 7, 8, 9, 10, 10 (least significant first), the result satisfies R1 at 64 bits.
- R6: In the uniform schedule with a segment size of 4 and a width of 18 (segments 4, 4, 4, 4, 2), the result satisfies R1 at 18 bits, including carries that cross into the short top segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case is a carry that is not known until it has crossed every segment boundary. In that case, every upper segment has to discard the speculative result it would choose on its own and take the other one. Uniform random operands rarely create a propagate run longer than a few bits. The stimulus therefore adds a walking pattern: the low k bits are all ones and the carry input is 1, for every k up to the full width. It also uses alternating-bit operands whose every position propagates. Together these force the late-arriving carry to flip each segment's multiplexer, in all three configurations.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic {
    SCHED_LIST    = 1'b0,
    SCHED_UNIFORM = 1'b1
  } sched_e;

  localparam int unsigned MAX_BLOCKS = 32;
  localparam int unsigned SZ_BITS    = 8;

  // Segment sizes packed one byte each, segment 0 in the lowest byte.
  typedef logic [MAX_BLOCKS*SZ_BITS-1:0] size_vec_t;

  function automatic int unsigned blk_count(sched_e sched, int unsigned width,
                                            int unsigned uni, int unsigned nlist);
    if (sched == SCHED_UNIFORM) return (width + uni - 1) / uni;
    return nlist;
  endfunction

  function automatic int unsigned blk_size(sched_e sched, int unsigned width,
                                           int unsigned uni, size_vec_t sizes,
                                           int unsigned idx);
    int unsigned lo;
    if (sched == SCHED_UNIFORM) begin
      lo = idx * uni;
      if (lo >= width) return 0;
      return ((width - lo) < uni) ? (width - lo) : uni;
    end
    return int'(sizes[idx*SZ_BITS +: SZ_BITS]);
  endfunction

  function automatic int unsigned blk_lo(sched_e sched, int unsigned width,
                                         int unsigned uni, size_vec_t sizes,
                                         int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < MAX_BLOCKS; j++) begin
      if (j < idx) acc += blk_size(sched, width, uni, sizes, j);
    end
    return acc;
  endfunction

endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < W; g++) begin : g_fa
    logic half;
    assign half         = a[g] ^ b[g];
    assign sum[g]       = half ^ chain[g];
    assign chain[g+1]   = (a[g] & b[g]) | (chain[g] & half);
  end

  assign cout = chain[W];

endmodule

// File: rtl/csel_block.sv
module csel_block #(
  parameter int unsigned W         = 4,
  parameter bit          SPECULATE = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         cout_if0,
  output logic         cout_if1
);

  if (SPECULATE) begin : g_pair
    logic [W-1:0] sum_z, sum_o;
    logic         co_z, co_o;

    csel_rca #(.W(W)) u_rca_zero (
      .a(a), .b(b), .cin(1'b0), .sum(sum_z), .cout(co_z)
    );
    csel_rca #(.W(W)) u_rca_one (
      .a(a), .b(b), .cin(1'b1), .sum(sum_o), .cout(co_o)
    );

    assign sum      = cin ? sum_o : sum_z;
    assign cout     = cin ? co_o  : co_z;
    assign cout_if0 = co_z;
    assign cout_if1 = co_o;
  end else begin : g_single
    logic co_r;
    csel_rca #(.W(W)) u_rca (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(co_r)
    );
    assign cout     = co_r;
    assign cout_if0 = co_r;
    assign cout_if1 = co_r;
  end

endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_pkg::*;
#(
  parameter int unsigned WIDTH     = 16,
  parameter sched_e      SCHED     = SCHED_LIST,
  parameter int unsigned NBLK      = 5,
  parameter int unsigned UNI_BLK   = 4,
  parameter size_vec_t   BLK_SIZES = size_vec_t'(40'h05_04_03_02_02)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned NB    = blk_count(SCHED, WIDTH, UNI_BLK, NBLK);
  localparam int unsigned TOTAL = blk_lo(SCHED, WIDTH, UNI_BLK, BLK_SIZES, NB);

  if (NB == 0 || NB > MAX_BLOCKS) begin : g_bad_count
    $error("csel_adder: segment count out of range");
  end
  if (TOTAL != WIDTH) begin : g_bad_total
    $error("csel_adder: segment sizes do not add up to WIDTH");
  end

  // carry[k] is the resolved carry entering segment k.
  logic [NB:0]   carry;
  logic [NB-1:0] cy0, cy1;

  assign carry[0] = cin;

  for (genvar blk = 0; blk < NB; blk++) begin : g_seg
    localparam int unsigned LO = blk_lo(SCHED, WIDTH, UNI_BLK, BLK_SIZES, blk);
    localparam int unsigned SW = blk_size(SCHED, WIDTH, UNI_BLK, BLK_SIZES, blk);

    if (SW == 0) begin : g_bad_size
      $error("csel_adder: zero-sized segment");
    end else begin : g_ok
      csel_block #(.W(SW), .SPECULATE(blk != 0)) u_seg (
        .a       (a[LO +: SW]),
        .b       (b[LO +: SW]),
        .cin     (carry[blk]),
        .sum     (sum[LO +: SW]),
        .cout    (carry[blk+1]),
        .cout_if0(cy0[blk]),
        .cout_if1(cy1[blk])
      );
    end
  end

  assign cout = carry[NB];

endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk
  import csel_pkg::*;
#(
  parameter int unsigned WIDTH     = 16,
  parameter sched_e      SCHED     = SCHED_LIST,
  parameter int unsigned NBLK      = 5,
  parameter int unsigned UNI_BLK   = 4,
  parameter size_vec_t   BLK_SIZES = size_vec_t'(40'h05_04_03_02_02),
  localparam int unsigned NB       = blk_count(SCHED, WIDTH, UNI_BLK, NBLK)
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NB:0]      carry,
  input logic [NB-1:0]    cy0,
  input logic [NB-1:0]    cy1
);

  localparam int unsigned W0 = blk_size(SCHED, WIDTH, UNI_BLK, BLK_SIZES, 0);

  always_comb begin
    AST_SUM_EXACT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
      else $error("sum mismatch"); // R1
    AST_LOW_CIN: assert ({carry[1], sum[W0-1:0]} ==
                         ({1'b0, a[W0-1:0]} + {1'b0, b[W0-1:0]} + (W0+1)'(cin)))
      else $error("low segment mismatch"); // R3
  end

  for (genvar blk = 1; blk < NB; blk++) begin : g_seg_chk
    localparam int unsigned LO = blk_lo(SCHED, WIDTH, UNI_BLK, BLK_SIZES, blk);
    localparam int unsigned SW = blk_size(SCHED, WIDTH, UNI_BLK, BLK_SIZES, blk);
    always_comb begin
      AST_SEG_RESULT: assert ({carry[blk+1], sum[LO +: SW]} ==
                              ({1'b0, a[LO +: SW]} + {1'b0, b[LO +: SW]} + (SW+1)'(carry[blk])))
        else $error("segment result mismatch"); // R4
      AST_CAND_ORDER: assert (!cy0[blk] || cy1[blk])
        else $error("candidate carries out of order"); // R4
    end
  end

endmodule

bind csel_adder csel_adder_chk #(
  .WIDTH(WIDTH), .SCHED(SCHED), .NBLK(NBLK), .UNI_BLK(UNI_BLK), .BLK_SIZES(BLK_SIZES)
) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .carry(carry), .cy0(cy0), .cy1(cy1)
);

// File: tb/csel_adder_tb.sv
module csel_adder_tb;
  import csel_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  logic [63:0] a64 = '0, b64 = '0, s64;
  logic        c64 = 1'b0, co64;
  logic [17:0] a18 = '0, b18 = '0, s18;
  logic        c18 = 1'b0, co18;

  csel_adder u_dut (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));

  csel_adder #(
    .WIDTH(64), .SCHED(SCHED_LIST), .NBLK(10),
    .BLK_SIZES(size_vec_t'(80'h0A0A_0908_0706_0504_0302))
  ) u_dut_w64 (.a(a64), .b(b64), .cin(c64), .sum(s64), .cout(co64));

  csel_adder #(
    .WIDTH(18), .SCHED(SCHED_UNIFORM), .UNI_BLK(4)
  ) u_dut_uni (.a(a18), .b(b18), .cin(c18), .sum(s18), .cout(co18));

  function automatic logic [64:0] ref_add(logic [63:0] x, logic [63:0] y, logic c, int w);
    logic [64:0] t;
    logic [63:0] m;
    m = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    t = {1'b0, x & m} + {1'b0, y & m} + 65'(c);
    return {t[w], t[63:0] & m};
  endfunction

  // which: 0 = 16-bit list, 1 = 64-bit list, 2 = 18-bit uniform
  task automatic apply(int which, logic [63:0] x, logic [63:0] y, logic c, string req);
    logic [64:0] got, exp;
    int w;
    @(negedge clk);
    case (which)
      0: begin a16 = x[15:0]; b16 = y[15:0]; c16 = c; w = 16; end
      1: begin a64 = x;       b64 = y;       c64 = c; w = 64; end
      default: begin a18 = x[17:0]; b18 = y[17:0]; c18 = c; w = 18; end
    endcase
    #1;
    case (which)
      0: got = {co16, 48'd0, s16};
      1: got = {co64, s64};
      default: got = {co18, 46'd0, s18};
    endcase
    exp = ref_add(x, y, c, w);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s w=%0d a=%h b=%h cin=%b actual=%h expected=%h",
               req, w, x, y, c, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C5A));
    repeat (2) @(posedge clk);

    // R1: idle inputs and a plain sum
    apply(0, 64'h0, 64'h0, 1'b0, "R1");
    apply(0, 64'h1234, 64'h4321, 1'b0, "R1");

    // R3: carry input alone, and pass-through with no carry
    apply(0, 64'h0, 64'h0, 1'b1, "R3");
    apply(0, 64'hFFFF, 64'h0, 1'b0, "R3");
    apply(0, 64'h0003, 64'h0, 1'b1, "R3");

    // R2: walking carry-generate prefix across every boundary
    for (int k = 1; k <= 16; k++) begin
      logic [63:0] p;
      p = (k == 64) ? '1 : ((64'd1 << k) - 64'd1);
      apply(0, p, 64'h0, 1'b1, "R2");
    end

    // R4: full-propagate operands flip every segment select
    apply(0, 64'h5555, 64'hAAAA, 1'b0, "R4");
    apply(0, 64'h5555, 64'hAAAA, 1'b1, "R4");
    apply(0, 64'hFFFF, 64'hFFFF, 1'b0, "R4");
    apply(0, 64'hFFFF, 64'hFFFF, 1'b1, "R4");

    // R1: random 16-bit
    for (int i = 0; i < 500; i++)
      apply(0, {32'd0, $urandom}, {32'd0, $urandom}, 1'($urandom), "R1");

    // R5: 64-bit list schedule
    apply(1, '1, 64'h0, 1'b1, "R5");
    apply(1, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R5");
    for (int k = 1; k <= 64; k++) begin
      logic [63:0] p;
      p = (k == 64) ? '1 : ((64'd1 << k) - 64'd1);
      apply(1, p, 64'h0, 1'b1, "R5");
    end
    for (int i = 0; i < 300; i++)
      apply(1, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R5");

    // R6: 18-bit uniform schedule with a short top segment
    apply(2, 64'h3FFFF, 64'h0, 1'b1, "R6");
    apply(2, 64'h15555, 64'h2AAAA, 1'b1, "R6");
    apply(2, 64'h3FFFF, 64'h3FFFF, 1'b1, "R6");
    for (int k = 1; k <= 18; k++)
      apply(2, (64'd1 << k) - 64'd1, 64'h0, 1'b1, "R6");
    for (int i = 0; i < 300; i++)
      apply(2, {32'd0, $urandom}, {32'd0, $urandom}, 1'($urandom), "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule